// File: doc/BRIEF.md
# One-time-enabled watchdog timer

This block is a recovery watchdog for a small 8-bit microcontroller. It listens on a plain register write bus (address, write data, write strobe) and watches for a two-byte key written to one fixed address. The first complete key arms the watchdog. Every later complete key restarts its count. Software cannot disarm it. Only a hardware reset or the watchdog's own overflow returns it to the idle state.

Once armed, a 14-bit counter advances on every oscillator clock edge at which the machine-cycle enable is high. When the counter passes its top value, the block raises its reset output for a fixed number of oscillator periods. While that pulse is high, the block holds itself idle and ignores the bus. The key register is write-only, and the count is not visible on the bus.

Top module: `wdog_oneshot`

## Requirements
- R1: After a hardware reset the watchdog is disarmed and `wdt_rst_o` is low. It stays low for any number of machine cycles until a complete key arrives.
- R2: A write of 0x1E to address 0xA6, followed by the next write to address 0xA6 carrying 0xE1, arms the watchdog. Arming takes effect at the clock edge that ends the 0xE1 write, and the count starts from 0 at that edge.
- R3: Any write to 0xA6 that follows a pending 0x1E and carries a value other than 0xE1 cancels the pending key. A 0xE1 written with no 0x1E pending has no effect. Writes to any other address leave a pending key untouched.
- R4: Once armed, no write pattern on the bus disarms the watchdog or stops its count.
- R5: The count advances only at edges where `mc_en` is high. The reset pulse starts at the 16384th such edge after the arming edge, not counting the arming edge itself.
- R6: A complete key written while armed clears the count. The next overflow then comes 16384 `mc_en` edges after the edge that ends that 0xE1 write.
- R7: On overflow, `wdt_rst_o` stays high for exactly 98 consecutive clock cycles.
- R8: The overflow disarms the watchdog and clears both the key state and the count. Key writes made while the pulse is high are ignored. After the pulse the watchdog stays disarmed until a new key arrives.
- R9: A low level on `rst_n` at any time, including during the pulse, disarms the watchdog and drives `wdt_rst_o` low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_en | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| wdt_rst_o | output | 1 | Reset request, high for the stretched pulse |

## Verification
The only port that shows internal state is the reset output, so a wrong state inside the block shows up late. A wrong key state or enable latch appears as a pulse that never comes, or one that comes without a key, and only a full count period (about 16k machine cycles) later. A miscount moves the rising edge of the pulse by that many cycles. The bench therefore runs each scenario for more than a full period and compares the exact edge of the pulse rise and the exact length of the pulse with a cycle-level reference. A stretcher fault shows up within 98 cycles as a pulse of the wrong length.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        KEY_IDLE = 1'b0,
        KEY_HALF = 1'b1
    } key_st_e;

    localparam int unsigned DEF_CNT_W     = 14;
    localparam int unsigned DEF_PULSE_LEN = 98;
    localparam logic [7:0]  DEF_KEY_ADDR  = 8'hA6;
    localparam logic [7:0]  DEF_KEY_FIRST = 8'h1E;
    localparam logic [7:0]  DEF_KEY_LAST  = 8'hE1;

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = DEF_KEY_ADDR,
    parameter logic [DATA_W-1:0] KEY_FIRST = DEF_KEY_FIRST,
    parameter logic [DATA_W-1:0] KEY_LAST  = DEF_KEY_LAST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              key_ok
);

    typedef struct packed {
        key_st_e st;
    } key_state_t;

    key_state_t st_d, st_q;
    logic       hit_addr;

    always_comb begin
        hit_addr = we && (addr == KEY_ADDR);
        key_ok   = hit_addr && (wdata == KEY_LAST) && (st_q.st == KEY_HALF) && !flush;
        st_d     = st_q;
        if (flush) begin
            st_d.st = KEY_IDLE;
        end else if (hit_addr) begin
            st_d.st = (wdata == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: KEY_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic armed,
    output logic ovf
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        ovf = s_q.armed && tick && (&s_q.cnt);
        s_d = s_q;
        if (ovf) begin
            s_d.armed = 1'b0;
            s_d.cnt   = '0;
        end else if (restart) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (s_q.armed && tick) begin
            s_d.cnt   = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign armed = s_q.armed;

endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
    parameter int unsigned PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    localparam int unsigned LW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;

    typedef struct packed {
        logic          on;
        logic [LW-1:0] left;
    } str_state_t;

    str_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            s_d.on   = 1'b1;
            s_d.left = LW'(PULSE_LEN - 1);
        end else if (s_q.on) begin
            if (s_q.left == '0) begin
                s_d.on = 1'b0;
            end else begin
                s_d.left = s_q.left - LW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.on;

endmodule

// File: rtl/wdog_oneshot.sv
module wdog_oneshot
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = DEF_CNT_W,
    parameter int unsigned PULSE_LEN = DEF_PULSE_LEN,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = DEF_KEY_ADDR,
    parameter logic [DATA_W-1:0] KEY_FIRST = DEF_KEY_FIRST,
    parameter logic [DATA_W-1:0] KEY_LAST  = DEF_KEY_LAST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic              sfr_we,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic              wdt_rst_o
);

    logic key_ok;
    logic armed;
    logic ovf;

    wdog_keyseq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_ADDR (KEY_ADDR),
        .KEY_FIRST(KEY_FIRST),
        .KEY_LAST (KEY_LAST)
    ) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (wdt_rst_o),
        .we    (sfr_we),
        .addr  (sfr_addr),
        .wdata (sfr_wdata),
        .key_ok(key_ok)
    );

    wdog_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(key_ok),
        .tick   (mc_en),
        .armed  (armed),
        .ovf    (ovf)
    );

    wdog_stretch #(
        .PULSE_LEN(PULSE_LEN)
    ) u_str (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (ovf),
        .pulse(wdt_rst_o)
    );

endmodule

// File: rtl/wdog_oneshot_chk.sv
module wdog_oneshot_chk #(
    parameter int unsigned PULSE_LEN = 98
) (
    input logic clk,
    input logic rst_n,
    input logic key_ok,
    input logic armed,
    input logic ovf,
    input logic wdt_rst_o
);

    localparam int unsigned RW = $clog2(PULSE_LEN + 2) + 1;

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (wdt_rst_o) begin
            hi_run <= hi_run + RW'(1);
        end else begin
            hi_run <= '0;
        end
    end

    // R2
    arm_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok && !ovf |=> armed);

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_ok));

    // R4
    no_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !ovf |=> armed);

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> wdt_rst_o);

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> $past(ovf));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (hi_run == RW'(PULSE_LEN)));

    // R8
    pulse_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> !armed);

endmodule

bind wdog_oneshot wdog_oneshot_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_ok   (key_ok),
    .armed    (armed),
    .ovf      (ovf),
    .wdt_rst_o(wdt_rst_o)
);

// File: tb/wdog_oneshot_test.sv
module wdog_oneshot_test;

    localparam int PERIOD    = 1 << 14;
    localparam int PULSE_LEN = 98;
    localparam int QUIET     = PERIOD + 150;
    localparam int LIMIT     = 199000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       wdt_rst_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    wdog_oneshot uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_en    (mc_en),
        .sfr_we   (sfr_we),
        .sfr_addr (sfr_addr),
        .sfr_wdata(sfr_wdata),
        .wdt_rst_o(wdt_rst_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc++;

    // Cycle-level reference of the requirements
    bit m_en, m_half, m_pulse, m_sel, m_hit, m_ovf;
    int m_cnt, m_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_half = 0; m_pulse = 0; m_cnt = 0; m_left = 0;
        end else begin
            m_sel = sfr_we && (sfr_addr == 8'hA6);
            m_hit = m_sel && (sfr_wdata == 8'hE1) && m_half && !m_pulse;
            m_ovf = m_en && mc_en && (m_cnt == PERIOD - 1);
            if (m_pulse) begin
                if (m_left == 0) m_pulse = 0; else m_left--;
                m_half = 0;
            end else if (m_ovf) begin
                m_pulse = 1; m_left = PULSE_LEN - 1;
                m_en = 0; m_cnt = 0; m_half = 0;
            end else begin
                if (m_sel) m_half = (sfr_wdata == 8'h1E);
                if (m_hit) begin
                    m_en = 1; m_cnt = 0;
                end else if (m_en && mc_en) begin
                    m_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // R5 R7: output follows the reference on every cycle
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(wdt_rst_o == m_pulse, "R5/R7", "reference compare", wdt_rst_o, m_pulse);
    end

    always @(negedge clk) begin
        if (!done && cyc > LIMIT) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog expired: cycles %0d expected below %0d", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic idle(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_o) highs++;
        end
    endtask

    task automatic wait_rise(output int at);
        while (!wdt_rst_o) @(negedge clk);
        at = cyc;
    endtask

    task automatic measure_pulse(input bit poke, output int len);
        len = 1;
        for (int i = 0; i < PULSE_LEN + 20; i++) begin
            if (poke && i == 0) begin sfr_we = 1; sfr_addr = 8'hA6; sfr_wdata = 8'h1E; end
            if (poke && i == 1) begin sfr_wdata = 8'hE1; end
            if (i == 2) sfr_we = 0;
            @(negedge clk);
            if (wdt_rst_o) len++;
        end
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        #1;
        chk(wdt_rst_o == 1'b0, "R9", "output during reset", wdt_rst_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int h, t_arm, t_rise, len, r;
        void'($urandom(32'h5EED_0A6));
        mc_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(wdt_rst_o == 1'b0, "R1", "output in reset", wdt_rst_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wdt_rst_o == 1'b0, "R1", "output after reset", wdt_rst_o, 0);
        idle(QUIET, h);
        chk(h == 0, "R1", "pulse cycles without key", h, 0);

        // R3: wrong or out-of-order keys never arm
        wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
        wr(8'hA7, 8'h1E); wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);
        idle(QUIET, h);
        chk(h == 0, "R3", "pulse cycles after bad keys", h, 0);

        // R2 R3: interleaved foreign write keeps key pending
        wr(8'hA6, 8'h1E); wr(8'h80, 8'hE1); wr(8'hA6, 8'hE1);
        t_arm = cyc;
        // R4: attempts to disarm
        wr(8'hA6, 8'h00); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55);
        wr(8'hA6, 8'hFF); wr(8'hA6, 8'hE1);
        wait_rise(t_rise);
        chk(t_rise - t_arm == PERIOD, "R4", "edges from arm to pulse", t_rise - t_arm, PERIOD);
        // R8: key written during pulse is ignored
        measure_pulse(1'b1, len);
        chk(len == PULSE_LEN, "R7", "pulse length", len, PULSE_LEN);
        idle(QUIET, h);
        chk(h == 0, "R8", "pulse cycles after overflow", h, 0);

        // R6: service restarts count
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        idle(12000, h);
        chk(h == 0, "R6", "pulse before service", h, 0);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        t_arm = cyc;
        wait_rise(t_rise);
        chk(t_rise - t_arm == PERIOD, "R6", "edges from service to pulse", t_rise - t_arm, PERIOD);
        measure_pulse(1'b0, len);
        chk(len == PULSE_LEN, "R7", "pulse length after service", len, PULSE_LEN);

        // R9: hardware reset while armed
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        idle(5000, h);
        hw_reset();
        idle(QUIET, h);
        chk(h == 0, "R9", "pulse cycles after reset while armed", h, 0);

        // R9: hardware reset during pulse
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        wait_rise(t_rise);
        idle(10, h);
        chk(h == 10, "R7", "pulse held mid-way", h, 10);
        hw_reset();
        idle(200, h);
        chk(h == 0, "R9", "pulse cycles after reset in pulse", h, 0);

        // R5: random machine-cycle pacing and random bus traffic
        for (int i = 0; i < 9000; i++) begin
            mc_en = ($urandom % 2) == 0;
            sfr_we = ($urandom % 4) == 0;
            sfr_addr = (($urandom % 5) == 0) ? 8'($urandom) : 8'hA6;
            r = $urandom % 10;
            sfr_wdata = (r < 4) ? 8'h1E : (r < 8) ? 8'hE1 : 8'($urandom);
            @(negedge clk);
        end
        sfr_we = 1'b0;
        mc_en = 1'b1;
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        for (int i = 0; i < 20000; i++) begin
            mc_en = ($urandom % 10) != 0;
            sfr_we = ($urandom % 200) == 0;
            sfr_addr = (($urandom % 3) == 0) ? 8'hA6 : 8'($urandom);
            sfr_wdata = (($urandom % 2) == 0) ? 8'h1E : 8'($urandom);
            @(negedge clk);
        end
        sfr_we = 1'b0;
        idle(50, h);
        finish_run();
    end

endmodule